// File: doc/BRIEF.md
# Addressed Three-Wire Serial Display Loader

This block takes frames from a host on three slow inputs (enable, serial clock, serial data), all oversampled by the system clock. While enable is low, the host shifts in an 8-bit device address. Enable then goes high and the host sends one or more 64-bit groups of payload. Each group holds 52 display bits, an 8-bit control field and four padding bits. When enable drops, a frame that passed the address check and has a whole number of groups is copied into the output registers. The waveform generator reads those registers.

The outputs are a 204-bit display image and five control fields: low-current mode, a 4-bit port-select code, half-bias select, segment blanking and power saving. A short frame of one, two or three groups refreshes only the leading display bits and leaves the rest as they were. Every accepted frame refreshes the control field. A one-cycle strobe marks each register update. A done flag tells the system when the image is defined, so the panel can be kept blanked until then.

Top module: `lcd_serial_loader`

## Requirements
- R1: The address is 8 bits, sent least significant bit first on rising serial-clock edges while enable is low. Only the value 0x41 opens a frame. With any other value the whole frame is ignored: no output changes and no strobe is raised.
- R2: Payload bits are sampled on rising serial-clock edges while enable is high. Payload bit k (counting from 0) belongs to group g = k/64 at position p = k%64. Positions 0..51 load dispImage bit 52*g+p. Display indices of 204 and above are dropped. Positions 60..63 are ignored.
- R3: Positions 52..59 of a group form the control field. Position 52 is curLow, 53..56 are portSel bits 0..3, 57 is biasHalf, 58 is segOff and 59 is powerSave. When a frame carries several groups, the control field of its last group is the one applied.
- R4: Frames of 64, 128, 192 or 256 payload bits are accepted. Display bits that belong to groups not sent keep their previous values.
- R5: A frame of 0 bits, of a length that is not a multiple of 64, or of more than 256 bits is discarded. Nothing changes and no strobe is raised.
- R6: No output register changes while a frame is in progress. An accepted frame takes effect only after enable falls.
- R7: Frames work the same way whether the serial clock rests low or rests high between bits and between frames.
- R8: updStrobe is high for exactly one system-clock cycle per accepted frame, and is low at all other times.
- R9: loadDone is low from reset until the first accepted frame. From then on it stays high.
- R10: After reset, dispImage, all control outputs, updStrobe and loadDone are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rstN | input | 1 | Active-low synchronous reset |
| enIn | input | 1 | Frame enable: low for the address phase, high for payload |
| serClkIn | input | 1 | Serial clock; bits are taken on its rising edge |
| serDatIn | input | 1 | Serial data |
| dispImage | output | 204 | Committed display image, one bit per segment and common pair |
| curLow | output | 1 | Low-current drive mode |
| portSel | output | 4 | Count of leading segment pins used as plain outputs |
| biasHalf | output | 1 | 1 selects half bias, 0 selects third bias |
| segOff | output | 1 | Segment outputs blanked |
| powerSave | output | 1 | Power-saving mode |
| updStrobe | output | 1 | One-cycle pulse after each register update |
| loadDone | output | 1 | At least one frame has been committed since reset |

## Verification
The hardest case to reach is a short frame that lands on top of an image a long frame has already loaded. The bits that must survive are only visible if they hold values that differ from what a short frame could write. The stimulus therefore loads a full random 256-bit image first, then sends 64-, 128- and 192-bit frames with fresh random data. It also sends discarded frames of odd length, of zero length, of excess length and with the bit-reversed address. After each one the whole image is compared against the bench model. Both serial-clock rest levels are mixed in at random.

// File: rtl/lcdldr_pkg.sv
package lcdldr_pkg;
  localparam int GROUP_BITS     = 64;
  localparam int DISP_PER_GROUP = 52;
  localparam int CTL_BITS       = 8;
  localparam int MAX_GROUPS     = 4;
  localparam int POS_W          = $clog2(GROUP_BITS);
  localparam int GRP_W          = $clog2(MAX_GROUPS);
  localparam int NG_W           = GRP_W + 1;
  localparam int CNT_W          = POS_W + NG_W;

  // strobes from the frame control to the datapath
  typedef struct packed {
    logic             wrBit;
    logic             bitVal;
    logic [GRP_W-1:0] grp;
    logic [POS_W-1:0] pos;
    logic             commit;
    logic [NG_W-1:0]  nGroups;
  } strobe_t;
endpackage

// File: rtl/lcdldr_ctrl.sv
module lcdldr_ctrl
  import lcdldr_pkg::*;
#(
  parameter logic [7:0] ADDR_VAL    = 8'h41,
  parameter int         SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enIn,
  input  logic    serClkIn,
  input  logic    serDatIn,
  output strobe_t stb
);
  localparam int FULL = MAX_GROUPS * GROUP_BITS;

  logic [SYNC_STAGES-1:0] enSync, ckSync, dSync;
  logic enS, ckS, dS, enPrev, ckPrev;
  logic ckRise, enRise, enFall;
  logic [7:0] addrSh;
  logic addrOk, overrun, frameOk;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enSync <= '0;
      ckSync <= '0;
      dSync  <= '0;
      enPrev <= 1'b0;
      ckPrev <= 1'b0;
    end else begin
      enSync <= {enSync[SYNC_STAGES-2:0], enIn};
      ckSync <= {ckSync[SYNC_STAGES-2:0], serClkIn};
      dSync  <= {dSync[SYNC_STAGES-2:0], serDatIn};
      enPrev <= enS;
      ckPrev <= ckS;
    end
  end

  assign enS    = enSync[SYNC_STAGES-1];
  assign ckS    = ckSync[SYNC_STAGES-1];
  assign dS     = dSync[SYNC_STAGES-1];
  assign ckRise = ckS & ~ckPrev;
  assign enRise = enS & ~enPrev;
  assign enFall = ~enS & enPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrSh  <= '0;
      addrOk  <= 1'b0;
      bitCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      if (!enS && ckRise) addrSh <= {dS, addrSh[7:1]};
      if (enRise) begin
        addrOk  <= (addrSh == ADDR_VAL);
        bitCnt  <= '0;
        overrun <= 1'b0;
      end else if (enS && ckRise && addrOk) begin
        if (bitCnt == CNT_W'(FULL)) overrun <= 1'b1;
        else                        bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  assign frameOk = addrOk && !overrun && (bitCnt != '0) &&
                   (bitCnt[POS_W-1:0] == '0);

  always_comb begin
    stb.wrBit   = enS & ckRise & addrOk & (bitCnt != CNT_W'(FULL));
    stb.bitVal  = dS;
    stb.pos     = bitCnt[POS_W-1:0];
    stb.grp     = bitCnt[POS_W +: GRP_W];
    stb.commit  = enFall & frameOk;
    stb.nGroups = bitCnt[CNT_W-1:POS_W];
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FULL));
  p_commit_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> addrOk);
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enRise |=> $stable(addrOk));
  p_commit_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> !enS);
endmodule

// File: rtl/lcdldr_dpath.sv
module lcdldr_dpath
  import lcdldr_pkg::*;
#(
  parameter int DISP_BITS = 204
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  output logic [DISP_BITS-1:0] dispImage,
  output logic [CTL_BITS-1:0]  ctlWord,
  output logic                 updStrobe,
  output logic                 loadDone
);
  for (genvar i = 0; i < DISP_BITS; i++) begin : g_disp
    localparam int G = i / DISP_PER_GROUP;
    localparam int P = i % DISP_PER_GROUP;
    logic stBit, dpBit;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stBit <= 1'b0;
        dpBit <= 1'b0;
      end else begin
        if (stb.wrBit && stb.grp == GRP_W'(G) && stb.pos == POS_W'(P))
          stBit <= stb.bitVal;
        if (stb.commit && stb.nGroups > NG_W'(G))
          dpBit <= stBit;
      end
    end
    assign dispImage[i] = dpBit;
  end

  for (genvar j = 0; j < CTL_BITS; j++) begin : g_ctl
    localparam int P = DISP_PER_GROUP + j;
    logic stBit, cwBit;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stBit <= 1'b0;
        cwBit <= 1'b0;
      end else begin
        if (stb.wrBit && stb.pos == POS_W'(P)) stBit <= stb.bitVal;
        if (stb.commit) cwBit <= stBit;
      end
    end
    assign ctlWord[j] = cwBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updStrobe <= 1'b0;
      loadDone  <= 1'b0;
    end else begin
      updStrobe <= stb.commit;
      if (stb.commit) loadDone <= 1'b1;
    end
  end

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe);
  p_image_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |-> $stable(dispImage));
  p_ctl_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |-> $stable(ctlWord));
  p_load_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);
endmodule

// File: rtl/lcd_serial_loader.sv
module lcd_serial_loader
  import lcdldr_pkg::*;
#(
  parameter int         DISP_BITS   = 204,
  parameter logic [7:0] ADDR_VAL    = 8'h41,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enIn,
  input  logic                 serClkIn,
  input  logic                 serDatIn,
  output logic [DISP_BITS-1:0] dispImage,
  output logic                 curLow,
  output logic [3:0]           portSel,
  output logic                 biasHalf,
  output logic                 segOff,
  output logic                 powerSave,
  output logic                 updStrobe,
  output logic                 loadDone
);
  strobe_t stb;
  logic [CTL_BITS-1:0] ctlWord;

  lcdldr_ctrl #(.ADDR_VAL(ADDR_VAL), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enIn(enIn), .serClkIn(serClkIn),
    .serDatIn(serDatIn), .stb(stb)
  );

  lcdldr_dpath #(.DISP_BITS(DISP_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .dispImage(dispImage),
    .ctlWord(ctlWord), .updStrobe(updStrobe), .loadDone(loadDone)
  );

  assign curLow    = ctlWord[0];
  assign portSel   = ctlWord[4:1];
  assign biasHalf  = ctlWord[5];
  assign segOff    = ctlWord[6];
  assign powerSave = ctlWord[7];
endmodule

// File: tb/lcd_serial_loader_tb.sv
module lcd_serial_loader_tb;
  localparam int H = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, enIn, serClkIn, serDatIn;
  logic [203:0] dispImage;
  logic curLow, biasHalf, segOff, powerSave, updStrobe, loadDone;
  logic [3:0] portSel;

  lcd_serial_loader u_dut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .serClkIn(serClkIn),
    .serDatIn(serDatIn), .dispImage(dispImage), .curLow(curLow),
    .portSel(portSel), .biasHalf(biasHalf), .segOff(segOff),
    .powerSave(powerSave), .updStrobe(updStrobe), .loadDone(loadDone)
  );

  int nChk = 0, nFail = 0, strobeCnt = 0;
  bit done = 0;
  logic [203:0] expD = '0;
  logic [7:0]   expC = '0;
  logic         expL = 1'b0;

  always @(negedge clk) if (rstN && updStrobe) strobeCnt++;

  function automatic logic [7:0] ctlNow();
    return {powerSave, segOff, biasHalf, portSel, curLow};
  endfunction

  task automatic chk(bit ok, string tag, string what,
                     logic [203:0] act, logic [203:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic waitC(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(bit b, bit idleHi);
    serClkIn = 1'b0;
    serDatIn = b;
    waitC(H);
    serClkIn = 1'b1;
    waitC(H);
    if (!idleHi) begin
      serClkIn = 1'b0;
      waitC(H);
    end
  endtask

  // bench model of the requirements R1..R5
  function automatic bit accepts(logic [7:0] addr, int n);
    return addr == 8'h41 && n > 0 && n % 64 == 0 && n <= 256;
  endfunction

  task automatic model(logic [7:0] addr, int n, logic [319:0] fb);
    if (accepts(addr, n)) begin
      for (int k = 0; k < n; k++) begin
        int g = k / 64;
        int p = k % 64;
        if (p < 52 && 52 * g + p < 204) expD[52 * g + p] = fb[k];
        else if (p >= 52 && p < 60) expC[p - 52] = fb[k];
      end
      expL = 1'b1;
    end
  endtask

  task automatic sendFrame(logic [7:0] addr, int n, logic [319:0] fb,
                           bit idleHi, string tag);
    int sc0 = strobeCnt;
    int expS;
    enIn = 1'b0;
    serClkIn = idleHi;
    waitC(2 * H);
    for (int i = 0; i < 8; i++) sendBit(addr[i], idleHi);
    waitC(H);
    enIn = 1'b1;
    waitC(2 * H);
    for (int k = 0; k < n; k++) sendBit(fb[k], idleHi);
    waitC(2 * H);
    chk(dispImage == expD && ctlNow() == expC && strobeCnt == sc0,
        "R6", {tag, " outputs held during frame"},
        {ctlNow(), dispImage[195:0]}, {expC, expD[195:0]});
    enIn = 1'b0;
    waitC(10);
    expS = sc0 + (accepts(addr, n) ? 1 : 0);
    model(addr, n, fb);
    chk(dispImage == expD, "R2", {tag, " display image"}, dispImage, expD);
    chk(ctlNow() == expC, "R3", {tag, " control field"},
        204'(ctlNow()), 204'(expC));
    chk(strobeCnt == expS, "R8", {tag, " strobe count"},
        204'(strobeCnt), 204'(expS));
    chk(loadDone == expL, "R9", {tag, " load done"},
        204'(loadDone), 204'(expL));
  endtask

  function automatic logic [319:0] rndBits();
    logic [319:0] v;
    for (int w = 0; w < 10; w++) v[w * 32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      finishUp();
    end
  end

  initial begin
    logic [319:0] fb;
    void'($urandom(32'h5eed_0041));
    rstN = 1'b0; enIn = 1'b0; serClkIn = 1'b0; serDatIn = 1'b0;
    waitC(5);
    rstN = 1'b1;
    waitC(3);
    // R10 reset state
    chk(dispImage == '0, "R10", "reset image", dispImage, '0);
    chk(ctlNow() == '0 && updStrobe == 1'b0 && loadDone == 1'b0, "R10",
        "reset control/strobe/done",
        204'({ctlNow(), updStrobe, loadDone}), '0);

    // R1 wrong address before any load keeps R9 low
    sendFrame(8'h82, 64, rndBits(), 1'b0, "R1 bit-reversed address");
    sendFrame(8'h42, 256, rndBits(), 1'b0, "R1 wrong address");
    // R2 full load, idle low
    sendFrame(8'h41, 256, rndBits(), 1'b0, "R2 full 256-bit load");
    // R4 short frames keep untouched groups
    sendFrame(8'h41, 64, rndBits(), 1'b0, "R4 64-bit frame");
    sendFrame(8'h41, 128, rndBits(), 1'b1, "R4 128-bit frame");
    // R7 idle-high clock
    sendFrame(8'h41, 192, rndBits(), 1'b1, "R7 192-bit idle-high");
    // R3 last group control wins
    fb = rndBits();
    fb[52 +: 8] = 8'hA5;
    fb[116 +: 8] = 8'h3C;
    sendFrame(8'h41, 128, fb, 1'b0, "R3 last group control");
    // R5 discarded lengths
    sendFrame(8'h41, 100, rndBits(), 1'b0, "R5 100-bit frame");
    sendFrame(8'h41, 300, rndBits(), 1'b1, "R5 300-bit frame");
    sendFrame(8'h41, 0, rndBits(), 1'b0, "R5 empty frame");
    sendFrame(8'h41, 63, rndBits(), 1'b0, "R5 63-bit frame");

    // random mix
    for (int r = 0; r < 20; r++) begin
      logic [7:0] a = ($urandom % 4 == 0) ? 8'($urandom) : 8'h41;
      int sel = $urandom % 6;
      int n = (sel < 4) ? 64 * (sel + 1) : int'($urandom % 300);
      sendFrame(a, n, rndBits(), 1'($urandom), "R4 random frame");
    end

    done = 1;
    finishUp();
  end
endmodule